// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This combinational unit holds the correction arithmetic an integer core needs for its packed-decimal and unpacked-ASCII instructions. From the low accumulator byte, the high accumulator byte, an immediate byte, the incoming carry and auxiliary-carry flags, and a 3-bit operation code, it produces the new low and high bytes and all six arithmetic flags in the same cycle. The flag rules are deliberately irregular. The decimal adjusts never drop a carry they were given. The decimal subtract takes its carries only from its range tests. The unpacked adjusts report the adjust decision through sign, zero, carry and auxiliary carry, and pin parity and overflow.

Operation decode and register writeback belong to the surrounding core. The unit has no clock and no stored state: the decode stage drives the operands and the operation code, and samples the results in the same cycle. Operation codes 0 to 4 select the five adjusts. Codes 5 to 7 are reserved and pass the operands through.

Top module: `adj_unit`

## Requirements
- R1: Operation codes are: 0 decimal add adjust, 1 decimal subtract adjust, 2 ASCII add adjust, 3 ASCII subtract adjust, 4 ASCII divide prepare, 5-7 reserved. Flag bits are: [0] carry, [1] parity, [2] auxiliary carry, [3] zero, [4] sign, [5] overflow. Parity is 1 when the result byte holds an even number of ones. For reserved codes, both bytes pass through unchanged, carry equals the carry input, auxiliary carry equals the auxiliary input, and the other flags are 0.
- R2: For a decimal add adjust, the low condition is the auxiliary input or a low nybble above 9, and the high condition is the carry input or a byte above 0x99, both tested on the original low byte. The correction is 0x06 when the low condition holds plus 0x60 when the high condition holds. The low byte becomes its original value plus the correction, modulo 256. The high byte is unchanged.
- R3: After a decimal add adjust, sign, zero, parity and overflow come from the correcting addition. Carry is the addition's carry-out OR the high condition. Auxiliary carry is the addition's nybble carry OR the low condition, so neither carry is ever cleared by this adjust.
- R4: A decimal subtract adjust uses the same two conditions and the same correction as R2, and subtracts the correction from the low byte modulo 256. The high byte is unchanged.
- R5: After a decimal subtract adjust, carry equals the high condition and auxiliary carry equals the low condition. Sign, zero, parity and overflow come from the correcting subtraction.
- R6: For an ASCII add or subtract adjust, the adjust condition is the auxiliary input or a low nybble of the low byte above 9. When the condition holds, the low byte becomes the low nybble of the low byte plus 6 (add) or minus 6 (subtract), and the high byte is incremented (add) or decremented (subtract). When it does not hold, the low byte becomes its own low nybble and the high byte is unchanged. The upper nybble of the low byte is always 0.
- R7: After an ASCII add or subtract adjust, overflow is 0 and parity is 1. Carry, auxiliary carry and zero each equal the adjust condition, and sign is its inverse.
- R8: An ASCII divide prepare sets the low byte to (low byte × immediate + high byte) modulo 256 for any immediate value, and sets the high byte to 0.
- R9: After an ASCII divide prepare, the flags are those of an 8-bit addition of the high byte to the low byte of the product: carry-out, nybble carry, signed overflow, and sign, zero and parity of the sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (R1) |
| al_in | input | 8 | Low accumulator byte |
| ah_in | input | 8 | High accumulator byte |
| imm_in | input | 8 | Immediate multiplier for the divide prepare |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming auxiliary carry flag |
| al_out | output | 8 | New low byte |
| ah_out | output | 8 | New high byte |
| flags_out | output | 6 | New flags, bit layout per R1 |

## Verification
The bound checks take all inputs to be known and stable whenever their combinational process settles. A check evaluated while the operands are half-updated could see a mixture of an old and a new operation code. The bench therefore changes every input in a single step, one nanosecond after a rising clock edge, and compares the outputs at the following falling edge. Every 3-bit operation code is defined, including the reserved codes, so the stimulus sweeps all eight codes with pseudo-random bytes and both incoming flag values. Directed values sit on the 9/0x99 thresholds and the wrap-around points.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int MSB    = BYTE_W - 1;

    localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
    localparam logic [BYTE_W-1:0] PAIR_MAX  = {DIGIT_MAX, DIGIT_MAX};
    localparam logic [BYTE_W-1:0] LO_FIX    = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] HI_FIX    = LO_FIX << NIB_W;
    localparam logic [NIB_W-1:0]  NIB_FIX   = LO_FIX[NIB_W-1:0];

    typedef enum logic [2:0] {
        OP_DEC_ADD = 3'd0,
        OP_DEC_SUB = 3'd1,
        OP_ASC_ADD = 3'd2,
        OP_ASC_SUB = 3'd3,
        OP_ASC_DIV = 3'd4,
        OP_RSV5    = 3'd5,
        OP_RSV6    = 3'd6,
        OP_RSV7    = 3'd7
    } adj_op_e;

    // packed from bit 5 down to bit 0
    typedef struct packed {
        logic ov;
        logic sg;
        logic zr;
        logic hc;
        logic par;
        logic cy;
    } adj_flags_t;

    function automatic logic even_par(input logic [BYTE_W-1:0] v);
        return ~^v;
    endfunction
endpackage

// File: rtl/adj_byte_alu.sv
module adj_byte_alu
    import bcd_adj_pkg::*;
(
    input  logic [BYTE_W-1:0] opa,
    input  logic [BYTE_W-1:0] opb,
    input  logic              do_sub,
    output logic [BYTE_W-1:0] res,
    output adj_flags_t        fl
);
    logic [BYTE_W:0] wide;
    logic [NIB_W:0]  half;

    always_comb begin
        if (do_sub) begin
            wide = {1'b0, opa} - {1'b0, opb};
            half = {1'b0, opa[NIB_W-1:0]} - {1'b0, opb[NIB_W-1:0]};
        end else begin
            wide = {1'b0, opa} + {1'b0, opb};
            half = {1'b0, opa[NIB_W-1:0]} + {1'b0, opb[NIB_W-1:0]};
        end
        res    = wide[BYTE_W-1:0];
        fl.cy  = wide[BYTE_W];
        fl.hc  = half[NIB_W];
        fl.ov  = do_sub ? ((opa[MSB] != opb[MSB]) && (res[MSB] != opa[MSB]))
                        : ((opa[MSB] == opb[MSB]) && (res[MSB] != opa[MSB]));
        fl.sg  = res[MSB];
        fl.zr  = (res == '0);
        fl.par = even_par(res);
    end
endmodule

// File: rtl/adj_decimal.sv
module adj_decimal
    import bcd_adj_pkg::*;
(
    input  logic [BYTE_W-1:0] al,
    input  logic              cf,
    input  logic              af,
    input  logic              is_sub,
    output logic [BYTE_W-1:0] al_o,
    output adj_flags_t        fl_o
);
    logic              hi_need;
    logic              lo_need;
    logic [BYTE_W-1:0] corr;
    adj_flags_t        alu_fl;

    // range tests are taken on the original byte, high range first
    always_comb begin
        hi_need = cf | (al > PAIR_MAX);
        lo_need = af | (al[NIB_W-1:0] > DIGIT_MAX);
        corr    = (lo_need ? LO_FIX : '0) | (hi_need ? HI_FIX : '0);
    end

    adj_byte_alu u_alu (
        .opa    (al),
        .opb    (corr),
        .do_sub (is_sub),
        .res    (al_o),
        .fl     (alu_fl)
    );

    always_comb begin
        fl_o = alu_fl;
        if (is_sub) begin
            fl_o.cy = hi_need;
            fl_o.hc = lo_need;
        end else begin
            fl_o.cy = alu_fl.cy | hi_need;
            fl_o.hc = alu_fl.hc | lo_need;
        end
    end
endmodule

// File: rtl/adj_ascii.sv
module adj_ascii
    import bcd_adj_pkg::*;
(
    input  logic [NIB_W-1:0]  al_lo,
    input  logic [BYTE_W-1:0] ah,
    input  logic              af,
    input  logic              is_sub,
    output logic [BYTE_W-1:0] al_o,
    output logic [BYTE_W-1:0] ah_o,
    output adj_flags_t        fl_o
);
    logic             need;
    logic [NIB_W-1:0] nib_fix;

    always_comb begin
        need    = af | (al_lo > DIGIT_MAX);
        nib_fix = is_sub ? (al_lo - NIB_FIX) : (al_lo + NIB_FIX);
        al_o    = {{(BYTE_W-NIB_W){1'b0}}, (need ? nib_fix : al_lo)};
        if (!need)       ah_o = ah;
        else if (is_sub) ah_o = ah - BYTE_W'(1);
        else             ah_o = ah + BYTE_W'(1);
        fl_o.ov  = 1'b0;
        fl_o.par = 1'b1;
        fl_o.cy  = need;
        fl_o.hc  = need;
        fl_o.zr  = need;
        fl_o.sg  = ~need;
    end
endmodule

// File: rtl/adj_divprep.sv
module adj_divprep
    import bcd_adj_pkg::*;
(
    input  logic [BYTE_W-1:0] al,
    input  logic [BYTE_W-1:0] ah,
    input  logic [BYTE_W-1:0] imm,
    output logic [BYTE_W-1:0] al_o,
    output logic [BYTE_W-1:0] ah_o,
    output adj_flags_t        fl_o
);
    logic [BYTE_W-1:0] prod_lo;

    assign prod_lo = al * imm;
    assign ah_o    = '0;

    adj_byte_alu u_alu (
        .opa    (prod_lo),
        .opb    (ah),
        .do_sub (1'b0),
        .res    (al_o),
        .fl     (fl_o)
    );
endmodule

// File: rtl/adj_unit.sv
module adj_unit
    import bcd_adj_pkg::*;
(
    input  logic [2:0]        op_sel,
    input  logic [BYTE_W-1:0] al_in,
    input  logic [BYTE_W-1:0] ah_in,
    input  logic [BYTE_W-1:0] imm_in,
    input  logic              cf_in,
    input  logic              af_in,
    output logic [BYTE_W-1:0] al_out,
    output logic [BYTE_W-1:0] ah_out,
    output logic [5:0]        flags_out
);
    adj_op_e           op;
    logic [BYTE_W-1:0] dec_al;
    adj_flags_t        dec_fl;
    logic [BYTE_W-1:0] asc_al;
    logic [BYTE_W-1:0] asc_ah;
    adj_flags_t        asc_fl;
    logic [BYTE_W-1:0] div_al;
    logic [BYTE_W-1:0] div_ah;
    adj_flags_t        div_fl;
    adj_flags_t        fl_sel;

    assign op = adj_op_e'(op_sel);

    adj_decimal u_dec (
        .al     (al_in),
        .cf     (cf_in),
        .af     (af_in),
        .is_sub (op == OP_DEC_SUB),
        .al_o   (dec_al),
        .fl_o   (dec_fl)
    );

    adj_ascii u_asc (
        .al_lo  (al_in[NIB_W-1:0]),
        .ah     (ah_in),
        .af     (af_in),
        .is_sub (op == OP_ASC_SUB),
        .al_o   (asc_al),
        .ah_o   (asc_ah),
        .fl_o   (asc_fl)
    );

    adj_divprep u_div (
        .al     (al_in),
        .ah     (ah_in),
        .imm    (imm_in),
        .al_o   (div_al),
        .ah_o   (div_ah),
        .fl_o   (div_fl)
    );

    always_comb begin
        unique case (op)
            OP_DEC_ADD, OP_DEC_SUB: begin
                al_out = dec_al;
                ah_out = ah_in;
                fl_sel = dec_fl;
            end
            OP_ASC_ADD, OP_ASC_SUB: begin
                al_out = asc_al;
                ah_out = asc_ah;
                fl_sel = asc_fl;
            end
            OP_ASC_DIV: begin
                al_out = div_al;
                ah_out = div_ah;
                fl_sel = div_fl;
            end
            OP_RSV5, OP_RSV6, OP_RSV7: begin
                al_out    = al_in;
                ah_out    = ah_in;
                fl_sel    = '0;
                fl_sel.cy = cf_in;
                fl_sel.hc = af_in;
            end
        endcase
        flags_out = fl_sel;
    end
endmodule

// File: rtl/adj_unit_chk.sv
module adj_unit_chk
    import bcd_adj_pkg::*;
(
    input logic [2:0]        op_sel,
    input logic [BYTE_W-1:0] al_in,
    input logic [BYTE_W-1:0] ah_in,
    input logic              cf_in,
    input logic              af_in,
    input logic [BYTE_W-1:0] al_out,
    input logic [BYTE_W-1:0] ah_out,
    input logic [5:0]        flags_out
);
    adj_flags_t f;
    logic       is_asc;

    always_comb begin
        f      = flags_out;
        is_asc = (op_sel == OP_ASC_ADD) || (op_sel == OP_ASC_SUB);
        if (is_asc) begin
            AST_ASCII_FIXED_FLAGS: assert (!f.ov && f.par) else $error("ascii ov/par"); // R7
            AST_ASCII_TIED_FLAGS: assert (f.hc == f.cy && f.zr == f.cy && f.sg == !f.cy) else $error("ascii tie"); // R7
            AST_ASCII_MASKED: assert (al_out[BYTE_W-1:NIB_W] == '0) else $error("ascii mask"); // R6
        end
        if (op_sel == OP_ASC_DIV) begin
            AST_DIV_HIGH_CLEAR: assert (ah_out == '0) else $error("div ah"); // R8
        end
        if (op_sel == OP_DEC_ADD) begin
            AST_DEC_STICKY: assert ((!cf_in || f.cy) && (!af_in || f.hc)) else $error("sticky"); // R3
        end
        if (op_sel == OP_DEC_SUB) begin
            AST_DAS_CARRY_SRC: assert (f.cy == (cf_in || (al_in > PAIR_MAX))) else $error("das cy"); // R5
        end
        if (op_sel == OP_DEC_ADD || op_sel == OP_DEC_SUB) begin
            AST_DEC_HIGH_KEEP: assert (ah_out == ah_in) else $error("dec ah"); // R2
        end
        if (op_sel > OP_ASC_DIV) begin
            AST_RSV_PASS: assert (al_out == al_in && ah_out == ah_in) else $error("rsv"); // R1
        end
    end
endmodule

bind adj_unit adj_unit_chk chk_i (.*);

// File: tb/adj_unit_tb_top.sv
module adj_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel = '0;
    logic [7:0] al_in = '0, ah_in = '0, imm_in = '0;
    logic       cf_in = 1'b0, af_in = 1'b0;
    logic [7:0] al_out, ah_out;
    logic [5:0] flags_out;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0] al;
        logic [7:0] ah;
        logic [5:0] fl;
        string      rq_res;
        string      rq_fl;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    adj_unit dut_i (
        .op_sel    (op_sel),
        .al_in     (al_in),
        .ah_in     (ah_in),
        .imm_in    (imm_in),
        .cf_in     (cf_in),
        .af_in     (af_in),
        .al_out    (al_out),
        .ah_out    (ah_out),
        .flags_out (flags_out)
    );

    function automatic logic par8(input int r);
        logic [7:0] b = r[7:0];
        return ~^b;
    endfunction

    // reference model written from the requirements
    function automatic exp_t model(input int op, input int a, input int h,
                                   input int m, input bit c, input bit ac);
        exp_t e;
        int lo, hi, corr, r, t;
        bit cy, hc, ov;
        e.ah = h[7:0];
        case (op)
            0, 1: begin
                lo   = (ac || (a % 16) > 9) ? 1 : 0;
                hi   = (c || a > 'h99) ? 1 : 0;
                corr = lo * 'h06 + hi * 'h60;
                if (op == 0) begin
                    t  = a + corr;
                    r  = t % 256;
                    cy = (t > 255) || hi != 0;
                    hc = ((a % 16) + (corr % 16) > 15) || lo != 0;
                    ov = (((a ^ r) & (corr ^ r) & 'h80) != 0);
                    e.rq_res = "R2"; e.rq_fl = "R3";
                end else begin
                    r  = (a - corr + 256) % 256;
                    cy = hi != 0;
                    hc = lo != 0;
                    ov = (((a ^ corr) & (a ^ r) & 'h80) != 0);
                    e.rq_res = "R4"; e.rq_fl = "R5";
                end
                e.al = r[7:0];
                e.fl = {ov, r[7], r == 0, hc, par8(r), cy};
            end
            2, 3: begin
                lo = (ac || (a % 16) > 9) ? 1 : 0;
                if (lo != 0) begin
                    t    = (op == 2) ? a + 6 : a + 256 - 6;
                    e.al = 8'(t % 16);
                    t    = (op == 2) ? h + 1 : h + 255;
                    e.ah = 8'(t % 256);
                end else begin
                    e.al = 8'(a % 16);
                end
                e.fl = {1'b0, lo == 0, lo != 0, lo != 0, 1'b1, lo != 0};
                e.rq_res = "R6"; e.rq_fl = "R7";
            end
            4: begin
                t  = (a * m) % 256;
                r  = (t + h) % 256;
                cy = (t + h) > 255;
                hc = (t % 16) + (h % 16) > 15;
                ov = (((t ^ r) & (h ^ r) & 'h80) != 0);
                e.al = r[7:0];
                e.ah = 8'h00;
                e.fl = {ov, r[7], r == 0, hc, par8(r), cy};
                e.rq_res = "R8"; e.rq_fl = "R9";
            end
            default: begin
                e.al = a[7:0];
                e.fl = {4'b0000, 1'b0, 1'b0};
                e.fl[0] = c;
                e.fl[2] = ac;
                e.rq_res = "R1"; e.rq_fl = "R1";
            end
        endcase
        return e;
    endfunction

    task automatic drive(input int op, input int a, input int h, input int m,
                         input bit c, input bit ac);
        @(posedge clk);
        #1;
        op_sel = 3'(op);
        al_in  = a[7:0];
        ah_in  = h[7:0];
        imm_in = m[7:0];
        cf_in  = c;
        af_in  = ac;
        sb_q.push_back(model(op, a, h, m, c, ac));
    endtask

    // monitor: compare at the falling edge following each drive
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (al_out !== e.al || ah_out !== e.ah) begin
                n_bad++;
                $display("FAIL %s op=%0d al/ah act=%h/%h exp=%h/%h",
                         e.rq_res, op_sel, al_out, ah_out, e.al, e.ah);
            end
            n_chk++;
            if (flags_out !== e.fl) begin
                n_bad++;
                $display("FAIL %s op=%0d flags act=%b exp=%b",
                         e.rq_fl, op_sel, flags_out, e.fl);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        n_bad++;
        $display("FAIL watchdog act=expired exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lf = 32'h1ACE_B00C;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // idle state after reset: reserved code, all zero (R1)
        drive(5, 0, 0, 0, 0, 0);
        // R2/R3 thresholds: 0x9A gets both fixes and wraps to zero
        drive(0, 'h9A, 'h11, 0, 0, 0);
        drive(0, 'h99, 'h11, 0, 0, 0);
        drive(0, 'h00, 0, 0, 1, 1);
        drive(0, 'h45, 0, 0, 1, 0);
        // R4/R5
        drive(1, 'h9A, 'h22, 0, 0, 0);
        drive(1, 'h09, 0, 0, 0, 0);
        drive(1, 'h00, 0, 0, 1, 1);
        // R6/R7
        drive(2, 'h0A, 'h01, 0, 0, 0);
        drive(2, 'hF9, 'hFF, 0, 1, 0);
        drive(2, 'h37, 'hFF, 0, 0, 1);
        drive(3, 'h05, 'h00, 0, 0, 1);
        drive(3, 'hB9, 'h07, 0, 0, 0);
        // R8/R9
        drive(4, 'h07, 'h03, 10, 0, 0);
        drive(4, 'h55, 'h21, 0, 1, 1);
        drive(4, 'h10, 'h80, 'h10, 0, 0);
        drive(4, 'hFF, 'hFF, 'hFF, 0, 0);
        // R1 reserved codes keep operands
        drive(6, 'h3C, 'hC3, 'h77, 1, 0);
        drive(7, 'hA5, 'h5A, 'h11, 0, 1);
        // sweep every code with pseudo-random operands
        for (int op = 0; op < 8; op++) begin
            for (int k = 0; k < 250; k++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                drive(op, int'(lf[7:0]), int'(lf[15:8]), int'(lf[23:16]),
                      lf[24], lf[25]);
            end
        end
        while (sb_q.size() > 0) @(negedge clk);
        #2;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule